// File: doc/BRIEF.md
# Async PPP Frame Receive Status Tracker

This block sits after an asynchronous character receiver and turns its byte stream into per-frame receive status. It watches for the 0x7E flag and the 0x7D escape marker, un-escapes payload bytes, runs a 16-bit frame check over each frame and reports at the closing flag whether the frame ended cleanly, was aborted, or failed its check. Line faults (dropped bytes, bad stop bits, a held-low line) are collected into the same status byte.

In PPP mode, line faults accumulate silently over the packet and only the frame-closing events raise the interrupt. In SLIP mode the frame check bit is never set and line faults interrupt at once. A read strobe clears the status byte. The fault bits are also cleared when the next frame opens.

Top module: `ppp_rx_status`

## Requirements
- R1: After reset the status byte reads 0x00 and the interrupt is low.
- R2: A good byte 0x7E closing an open frame, not directly preceded by a good 0x7D, sets bit 6 (end of frame) one cycle later. No closing event appears before the flag.
- R3: A good 0x7D directly followed by a good 0x7E sets bit 5 (abort) and leaves bit 6 clear.
- R4: In PPP mode (ppp_mode_i=1) each payload byte, XORed with 0x20 when it follows a 0x7D, feeds a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF). Bit 4 is set with bit 6 when the register at the closing flag differs from 0xF0B8. In SLIP mode bit 4 is never set.
- R5: A byte strobed while buf_full_i=1 sets bit 3 (overrun) and is otherwise discarded.
- R6: A byte strobed with stop_ok_i=0 sets bit 2 (framing error) and is discarded. A frame holding such a byte closes with bits 5 and 2 set and bit 6 clear.
- R7: Ten consecutive line samples of 0 set bit 0 (break) on the tenth sample. A sample of 1 restarts the count.
- R8: In PPP mode bits 3, 2 and 0 alone never raise the interrupt. In SLIP mode any of them raises it when enabled.
- R9: irq_o is high only when rxdata_en_i=1 and bit 6 or bit 5 is set (or, in SLIP mode, bit 3, 2 or 0).
- R10: rd_i clears the whole status byte on the next edge. An event arriving in the same cycle as rd_i is kept.
- R11: The first non-flag byte after a flag clears bits 3, 2 and 0. Bits 7 and 1 always read 0.
- R12: A 0x7E received with no frame open produces no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | One-cycle strobe for a received character |
| byte_i | input | 8 | Received character |
| stop_ok_i | input | 1 | Stop bit of the character sampled as 1 |
| buf_full_i | input | 1 | No buffer space for the character |
| line_sample_i | input | 1 | Strobe for one raw line bit sample |
| line_bit_i | input | 1 | Raw line level at the sample strobe |
| ppp_mode_i | input | 1 | 1 = PPP mode, 0 = SLIP mode |
| rxdata_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Status read strobe, clears the status |
| status_o | output | 8 | Status: 6 end, 5 abort, 4 check error, 3 overrun, 2 framing, 0 break |
| irq_o | output | 1 | Interrupt request |

## Verification
Every status bit is registered once, so a character or line sample driven in one cycle shows up in status_o right after the next rising edge. irq_o follows the registered status through gating logic alone, so it changes in that same cycle. The bench drives each stimulus for exactly one clock on a falling edge and reads the outputs on the following falling edge, one edge after capture. Break detection is checked after the ninth and again after the tenth zero sample, which pins down the cycle in which the bit rises.

// File: rtl/ppp_rx_pkg.sv
package ppp_rx_pkg;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [7:0]  ESC_BYTE  = 8'h7D;
  localparam logic [7:0]  ESC_XOR   = 8'h20;
  localparam logic [15:0] FCS_INIT  = 16'hFFFF;
  localparam logic [15:0] FCS_POLY  = 16'h8408;
  localparam logic [15:0] FCS_GOOD  = 16'hF0B8;

  typedef struct packed {
    logic rsv7;
    logic eof;
    logic abort;
    logic fcs_err;
    logic ovr;
    logic fe;
    logic rsv1;
    logic brk;
  } rx_stat_t;
endpackage

// File: rtl/ppp_fcs16.sv
module ppp_fcs16
  import ppp_rx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         upd_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = init_i ? W'(FCS_INIT) : crc_q;
    if (upd_i) begin
      crc_d = crc_d ^ W'(data_i);
      for (int i = 0; i < 8; i++)
        crc_d = crc_d[0] ? ((crc_d >> 1) ^ W'(FCS_POLY)) : (crc_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) crc_q <= W'(FCS_INIT);
    else         crc_q <= crc_d;

  assign crc_o = crc_q;

  // R4
  fcs_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(init_i && !upd_i) |-> crc_o == W'(FCS_INIT));
endmodule

// File: rtl/ppp_break_det.sv
module ppp_break_det #(
  parameter int unsigned BREAK_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic bit_i,
  output logic break_o
);
  localparam int unsigned CW = $clog2(BREAK_BITS + 1);
  logic [CW-1:0] run_q;

  // one pulse per low run, on the sample that completes it
  assign break_o = sample_i && !bit_i && (run_q == CW'(BREAK_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) run_q <= '0;
    else if (sample_i) begin
      if (bit_i)                          run_q <= '0;
      else if (run_q != CW'(BREAK_BITS)) run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/ppp_rx_deframer.sv
module ppp_rx_deframer
  import ppp_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       stop_ok_i,
  input  logic       buf_full_i,
  input  logic       ppp_mode_i,
  output logic       start_o,
  output logic       eof_o,
  output logic       abort_o,
  output logic       fcs_err_o,
  output logic       ovr_o,
  output logic       fe_o
);
  logic in_frame_q, esc_q, frame_fe_q;
  logic good, is_flag, is_esc, close, fcs_upd;
  logic [7:0]  fcs_data;
  logic [15:0] crc;

  assign is_flag = byte_i == FLAG_BYTE;
  assign is_esc  = byte_i == ESC_BYTE;
  assign good    = byte_valid_i && stop_ok_i && !buf_full_i;
  assign ovr_o   = byte_valid_i && buf_full_i;
  assign fe_o    = byte_valid_i && !stop_ok_i;
  assign start_o = byte_valid_i && !in_frame_q && !(good && is_flag);
  assign close   = good && is_flag && in_frame_q;

  assign abort_o   = close && (esc_q || frame_fe_q);
  assign eof_o     = close && !abort_o;
  assign fcs_err_o = eof_o && ppp_mode_i && (crc != FCS_GOOD);

  // escape marker itself is not data
  assign fcs_upd  = good && !is_flag && !(is_esc && !esc_q);
  assign fcs_data = esc_q ? (byte_i ^ ESC_XOR) : byte_i;

  ppp_fcs16 #(.W(16)) fcs_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start_o),
    .upd_i  (fcs_upd),
    .data_i (fcs_data),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      esc_q      <= 1'b0;
      frame_fe_q <= 1'b0;
    end else begin
      if (close)        in_frame_q <= 1'b0;
      else if (start_o) in_frame_q <= 1'b1;
      if (good)         esc_q <= is_esc && !esc_q;
      frame_fe_q <= (start_o ? 1'b0 : frame_fe_q) | fe_o;
    end

  // R3
  abort_after_esc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(good && is_esc && !esc_q) && good && is_flag) |-> (abort_o && !eof_o));
endmodule

// File: rtl/ppp_rx_status.sv
module ppp_rx_status
  import ppp_rx_pkg::*;
#(
  parameter int unsigned BREAK_BITS = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       stop_ok_i,
  input  logic       buf_full_i,
  input  logic       line_sample_i,
  input  logic       line_bit_i,
  input  logic       ppp_mode_i,
  input  logic       rxdata_en_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  rx_stat_t stat_q, stat_d;
  logic start, eof, abort, fcs_err, ovr, fe, brk, any_ev;

  ppp_rx_deframer deframer_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .stop_ok_i    (stop_ok_i),
    .buf_full_i   (buf_full_i),
    .ppp_mode_i   (ppp_mode_i),
    .start_o      (start),
    .eof_o        (eof),
    .abort_o      (abort),
    .fcs_err_o    (fcs_err),
    .ovr_o        (ovr),
    .fe_o         (fe)
  );

  ppp_break_det #(.BREAK_BITS(BREAK_BITS)) break_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (line_sample_i),
    .bit_i    (line_bit_i),
    .break_o  (brk)
  );

  assign any_ev = eof | abort | fcs_err | ovr | fe | brk;

  // read clears everything, frame start clears line faults; new events win
  always_comb begin
    stat_d         = rd_i ? '0 : stat_q;
    stat_d.eof     = stat_d.eof | eof;
    stat_d.abort   = stat_d.abort | abort;
    stat_d.fcs_err = stat_d.fcs_err | fcs_err;
    stat_d.ovr     = ((rd_i || start) ? 1'b0 : stat_q.ovr) | ovr;
    stat_d.fe      = ((rd_i || start) ? 1'b0 : stat_q.fe)  | fe;
    stat_d.brk     = ((rd_i || start) ? 1'b0 : stat_q.brk) | brk;
    stat_d.rsv7    = 1'b0;
    stat_d.rsv1    = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;

  assign status_o = stat_q;
  assign irq_o = rxdata_en_i &&
                 (stat_q.eof || stat_q.abort ||
                  (!ppp_mode_i && (stat_q.ovr || stat_q.fe || stat_q.brk)));

  // R4
  fcs_needs_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.fcs_err) |-> stat_q.eof);
  // R4
  slip_no_fcs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.fcs_err) |-> $past(ppp_mode_i));
  // R9
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rxdata_en_i);
  // R8
  ppp_no_line_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppp_mode_i && !stat_q.eof && !stat_q.abort) |-> !irq_o);
  // R10
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !any_ev) |=> (status_o == 8'h00));
  // R7
  break_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q.brk) |-> $past(line_sample_i && !line_bit_i));
endmodule

// File: tb/ppp_rx_status_tb_top.sv
module ppp_rx_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, stop = 1'b1, full = 1'b0, rd = 1'b0;
  logic lsv = 1'b0, lbit = 1'b1, ppp = 1'b1, en = 1'b1;
  logic [7:0] bdat = 8'h00;
  logic [7:0] status;
  logic irq;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ppp_rx_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_i(bdat),
    .stop_ok_i(stop), .buf_full_i(full), .line_sample_i(lsv),
    .line_bit_i(lbit), .ppp_mode_i(ppp), .rxdata_en_i(en), .rd_i(rd),
    .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic st,
                      input logic fu, input logic r);
    @(negedge clk);
    bv = v; bdat = b; stop = st; full = fu; rd = r;
    @(negedge clk);
    bv = 1'b0; stop = 1'b1; full = 1'b0; rd = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    step(1'b1, b, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic put_data(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D || b < 8'h20) begin
      put(8'h7D);
      put(b ^ 8'h20);
    end else put(b);
  endtask

  task automatic rd_clear();
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic line(input logic b);
    @(negedge clk); lsv = 1'b1; lbit = b;
    @(negedge clk); lsv = 1'b0; lbit = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] fcs_add(input logic [15:0] c, input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl [16];
    logic [15:0] fcs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);

    // R2 R4 R9 R10 R12 sweep over mode, length, contents and corruption
    for (int m = 0; m < 2; m++)
      for (int len = 1; len <= 10; len++)
        for (int seed = 0; seed < 4; seed++) begin
          logic bad;
          ppp = m[0];
          en = len[0];
          bad = seed[0];
          for (int k = 0; k < len; k++) begin
            pl[k] = 8'(len * 37 + k * 91 + seed * 53);
            if (seed == 2 && k == 0) pl[k] = 8'h7E;
            if (seed == 2 && k == 1) pl[k] = 8'h7D;
          end
          fcs = 16'hFFFF;
          for (int k = 0; k < len; k++) fcs = fcs_add(fcs, pl[k]);
          fcs = ~fcs;
          if (bad) pl[len-1] = pl[len-1] ^ 8'h04;
          put(8'h7E);
          chk("R12 idle flag", status, 8'h00);
          for (int k = 0; k < len; k++) put_data(pl[k]);
          put_data(fcs[7:0]);
          put_data(fcs[15:8]);
          chk("R2 no early close", status, 8'h00);
          put(8'h7E);
          chk("R2/R4 close", status, 8'h40 | ((m == 1 && bad) ? 8'h10 : 8'h00));
          chk("R9 irq on close", {7'h0, irq}, {7'h0, en});
          rd_clear();
          chk("R10 read clears", status, 8'h00);
        end

    ppp = 1'b1; en = 1'b1;
    // R3 abort sequence
    put(8'h11); put(8'h7D); put(8'h7E);
    chk("R3 abort", status, 8'h20);
    chk("R9 irq abort", {7'h0, irq}, 8'h01);
    en = 1'b0; #1;
    chk("R9 irq gated", {7'h0, irq}, 8'h00);
    en = 1'b1;
    rd_clear();

    // R6 framing error forces abort encoding, R8 no irq meanwhile
    put(8'h11);
    step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);
    chk("R6 fe set", status, 8'h04);
    chk("R8 ppp fe no irq", {7'h0, irq}, 8'h00);
    put(8'h7E);
    chk("R6 fe abort", status, 8'h24);
    chk("R9 irq fe abort", {7'h0, irq}, 8'h01);
    rd_clear();

    // R5 overrun, R11 cleared on next frame start
    put(8'h11);
    step(1'b1, 8'h22, 1'b1, 1'b1, 1'b0);
    chk("R5 overrun", status, 8'h08);
    chk("R8 ppp ovr no irq", {7'h0, irq}, 8'h00);
    put(8'h7E);
    chk("R5 close after ovr", status, 8'h58);
    put(8'h33);
    chk("R11 start clears faults", status, 8'h50);
    rd_clear();
    chk("R10 cleared", status, 8'h00);
    // R10 event in same cycle as read wins
    step(1'b1, 8'h7E, 1'b1, 1'b0, 1'b1);
    chk("R10 set beats clear", status, 8'h50);
    rd_clear();

    // R8 SLIP mode line faults interrupt, R4 no check bit
    ppp = 1'b0;
    step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);
    chk("R8 slip fe", status, 8'h04);
    chk("R8 slip fe irq", {7'h0, irq}, 8'h01);
    put(8'h7E);
    chk("R6 slip fe abort", status, 8'h24);
    rd_clear();
    ppp = 1'b1;

    // R7 break run length sweep
    for (int n = 0; n <= 12; n++) begin
      line(1'b1);
      for (int k = 1; k <= n; k++) begin
        line(1'b0);
        if (k == 9)  chk("R7 nine zeros", status, 8'h00);
        if (k == 10) chk("R7 ten zeros", status, 8'h01);
      end
      line(1'b1);
      chk("R7 break result", status, (n >= 10) ? 8'h01 : 8'h00);
      chk("R8 ppp brk no irq", {7'h0, irq}, 8'h00);
      rd_clear();
    end
    // R11 reserved bits stay zero after a full status
    put(8'h11); step(1'b1, 8'h22, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 10; k++) line(1'b0);
    chk("R11 reserved zero", status & 8'h82, 8'h00);
    put(8'h7E);
    rd_clear();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule